// File: doc/BRIEF.md
# Record Queue Controller with Occupancy and Age Interrupt

This block runs a circular queue of fixed-size records that lives in an external memory. A producer delivers records one word per beat on a valid/ready stream. The block places each word at its address in the memory through a simple synchronous write port. A host CPU drains the queue through a small register interface. The CPU reads the write index, reads the records straight from memory, and then moves the read index itself. Hardware only ever moves the write index.

Indices count whole records. The slot for index `k` starts at word address `base + k * REC_WORDS`. Both indices wrap to zero at the programmed length. One slot always stays unused, so a full queue never looks the same as an empty one.

A level interrupt draws on two sticky causes. The first is occupancy above half the length. The second is a non-empty queue whose pending data has waited longer than a programmed number of cycles. Each cause has its own enable bit. `REC_WORDS` is a parameter, so one block serves both long cell records and short event records.

Top module: `rq_queue_ctl`

## Requirements
- R1: After reset, both indices read 0, the length reads `RST_LEN`, the timeout reads `RST_TMO`, the status and enable registers read 0, the overflow count reads 0, and `irq` is low.
- R2: Each accepted word `i` of a record (i = 0..REC_WORDS-1) is written with `mem_we` high to `mem_addr = base + wr_idx*REC_WORDS + i`, with `mem_wdata` equal to the input word. On the clock edge that accepts word REC_WORDS-1, the write index advances by one, and from LEN-1 it wraps to 0.
- R3: `in_ready` is always high once reset is released, so there is no back-pressure. A record whose first word arrives while the queue is full (occupancy = LEN-1) is dropped. None of its words assert `mem_we`, the write index stays put, and the overflow count (address 8) rises by one and saturates.
- R4: Only a CPU write to address 2 moves the read index. The queue is empty when both indices are equal. The occupancy register (address 7) reads (wr_idx - rd_idx) mod LEN.
- R5: A CPU write of a read index greater than or equal to LEN is ignored and sets status bit 2.
- R6: Status bit 0 becomes set when 2*occupancy > LEN.
- R7: Status bit 1 becomes set when the queue has stayed non-empty for at least the timeout value (address 4) in cycles. The age count is held at zero while the queue is empty. It restarts from zero on every accepted read-index write.
- R8: `irq` is high exactly when (status bit 0 AND enable bit 0) OR (status bit 1 AND enable bit 1), where the enable register is at address 5.
- R9: Writing 1 to a status bit (address 6) clears it. Writing 0 leaves it unchanged. A cause that is still present sets its bit again on the next cycle.
- R10: A write to the base (address 0) resets both indices to 0. A write to the length (address 1) with a value of 2 or more does the same. A length write below 2 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Record word offered |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| in_data | input | WORD_W | Record word |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | WORD_W | Memory write data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the following about the CPU and the producer:
- It never programs a length above the index range.
- It changes base or length only while no record is half delivered.
- It sets no base so high that a slot address would wrap the memory.

The bench follows these rules in every scenario:
- It changes base and length only between records.
- It keeps base small and the length well below the index range.
- It writes out-of-range read indices only to check that they are rejected.

Timing checks on the age cause leave several cycles of margin on either side of the threshold, so they do not depend on the exact edge at which the cause fires.

// File: rtl/rq_pkg.sv
package rq_pkg;
  localparam logic [3:0] A_BASE   = 4'd0;
  localparam logic [3:0] A_LEN    = 4'd1;
  localparam logic [3:0] A_RDIDX  = 4'd2;
  localparam logic [3:0] A_WRIDX  = 4'd3;
  localparam logic [3:0] A_TMO    = 4'd4;
  localparam logic [3:0] A_ENABLE = 4'd5;
  localparam logic [3:0] A_STATUS = 4'd6;
  localparam logic [3:0] A_OCC    = 4'd7;
  localparam logic [3:0] A_OVF    = 4'd8;

  localparam int ST_HALF  = 0;
  localparam int ST_AGE   = 1;
  localparam int ST_RDERR = 2;
endpackage

// File: rtl/rq_writer.sv
module rq_writer #(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 16,
  parameter int PTR_W     = 6,
  parameter int REC_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [PTR_W-1:0]  len,
  input  logic [ADDR_W-1:0] base,
  input  logic              full,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [PTR_W-1:0]  wr_idx,
  output logic              drop_start
);
  localparam int WIDX_W = (REC_WORDS > 1) ? $clog2(REC_WORDS) : 1;
  localparam logic [WIDX_W-1:0] WLAST = WIDX_W'(REC_WORDS - 1);

  logic [WIDX_W-1:0] widx;
  logic              drop_q;
  logic              accept;
  logic              dropping;
  logic              rec_end;
  logic [PTR_W-1:0]  wr_next;

  assign in_ready   = !rst;
  assign accept     = in_valid && in_ready;
  assign dropping   = (widx == '0) ? full : drop_q;
  assign drop_start = accept && (widx == '0) && full;
  assign rec_end    = accept && (widx == WLAST);
  assign wr_next    = (wr_idx == len - PTR_W'(1)) ? '0 : wr_idx + PTR_W'(1);

  assign mem_we    = accept && !dropping;
  assign mem_wdata = in_data;
  assign mem_addr  = base + ADDR_W'(wr_idx) * ADDR_W'(REC_WORDS) + ADDR_W'(widx);

  always_ff @(posedge clk) begin
    if (rst) begin
      widx   <= '0;
      drop_q <= 1'b0;
    end else if (accept) begin
      widx <= (widx == WLAST) ? '0 : widx + WIDX_W'(1);
      if (widx == '0) drop_q <= full;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                wr_idx <= '0;
    else if (rec_end && !dropping) wr_idx <= wr_next;
  end

  // R2: the write index only steps by one (mod LEN) or is cleared
  p_wr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(wr_idx) && !$past(clr)) |->
      (wr_idx == (($past(wr_idx) == $past(len) - PTR_W'(1)) ? '0 : $past(wr_idx) + PTR_W'(1))));

  // R3: dropped records never reach memory
  p_drop_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && widx != '0 && drop_q) |-> !mem_we);
endmodule

// File: rtl/rq_level.sv
module rq_level #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [PTR_W-1:0] rd_idx,
  input  logic [PTR_W-1:0] len,
  output logic [PTR_W-1:0] occ,
  output logic             empty,
  output logic             full,
  output logic             half
);
  logic [PTR_W:0] wrap_sum;

  assign wrap_sum = {1'b0, wr_idx} + {1'b0, len} - {1'b0, rd_idx};
  assign occ   = (wr_idx >= rd_idx) ? (wr_idx - rd_idx) : wrap_sum[PTR_W-1:0];
  assign empty = (wr_idx == rd_idx);
  assign full  = (occ == len - PTR_W'(1));
  assign half  = ({occ, 1'b0} > {1'b0, len});

  // R4: occupancy never reaches the programmed length
  p_occ_bound_r4: assert property (@(posedge clk) disable iff (rst) occ < len);
endmodule

// File: rtl/rq_age.sv
module rq_age #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             empty,
  input  logic             restart,
  input  logic [TMR_W-1:0] tmo,
  output logic             aged
);
  logic [TMR_W-1:0] age;

  always_ff @(posedge clk) begin
    if (rst || empty || restart) age <= '0;
    else if (age != '1)          age <= age + TMR_W'(1);
  end

  assign aged = !empty && (age >= tmo);

  // R7: the age count is zero whenever the queue has been empty
  p_age_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $past(empty) |-> (age == '0));
endmodule

// File: rtl/rq_queue_ctl.sv
module rq_queue_ctl #(
  parameter int ADDR_W    = 16,
  parameter int WORD_W    = 16,
  parameter int PTR_W     = 6,
  parameter int REC_WORDS = 4,
  parameter int TMR_W     = 16,
  parameter int OVF_W     = 16,
  parameter int RST_LEN   = 8,
  parameter int RST_TMO   = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  import rq_pkg::*;

  logic [ADDR_W-1:0] base;
  logic [PTR_W-1:0]  len;
  logic [PTR_W-1:0]  rd_idx;
  logic [PTR_W-1:0]  wr_idx;
  logic [TMR_W-1:0]  tmo;
  logic [1:0]        enable;
  logic [2:0]        status;
  logic [OVF_W-1:0]  ovf_cnt;
  logic [PTR_W-1:0]  occ;
  logic              empty, full, half, aged, drop_start;
  logic              wr_base, wr_len_ok, wr_rd, rd_ok, clr_idx;
  logic [2:0]        st_set, st_clr;
  logic              unused_wbits;

  assign wr_base   = reg_wr && (reg_addr == A_BASE);
  assign wr_len_ok = reg_wr && (reg_addr == A_LEN) && (reg_wdata[PTR_W-1:0] >= PTR_W'(2));
  assign wr_rd     = reg_wr && (reg_addr == A_RDIDX);
  assign rd_ok     = reg_wdata[PTR_W-1:0] < len && (reg_wdata[31:PTR_W] == '0);
  assign clr_idx   = wr_base || wr_len_ok;
  assign unused_wbits = ^reg_wdata;

  rq_writer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PTR_W(PTR_W), .REC_WORDS(REC_WORDS)) u_wr (
    .clk(clk), .rst(rst), .clr(clr_idx), .len(len), .base(base), .full(full),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wr_idx(wr_idx), .drop_start(drop_start)
  );

  rq_level #(.PTR_W(PTR_W)) u_lvl (
    .clk(clk), .rst(rst), .wr_idx(wr_idx), .rd_idx(rd_idx), .len(len),
    .occ(occ), .empty(empty), .full(full), .half(half)
  );

  rq_age #(.TMR_W(TMR_W)) u_age (
    .clk(clk), .rst(rst), .empty(empty), .restart(wr_rd && rd_ok),
    .tmo(tmo), .aged(aged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base   <= '0;
      len    <= PTR_W'(RST_LEN);
      rd_idx <= '0;
      tmo    <= TMR_W'(RST_TMO);
      enable <= '0;
    end else begin
      if (wr_base)   base <= reg_wdata[ADDR_W-1:0];
      if (wr_len_ok) len  <= reg_wdata[PTR_W-1:0];
      if (clr_idx)            rd_idx <= '0;
      else if (wr_rd && rd_ok) rd_idx <= reg_wdata[PTR_W-1:0];
      if (reg_wr && reg_addr == A_TMO)    tmo    <= reg_wdata[TMR_W-1:0];
      if (reg_wr && reg_addr == A_ENABLE) enable <= reg_wdata[1:0];
    end
  end

  assign st_set = {wr_rd && !rd_ok, aged, half};
  assign st_clr = (reg_wr && reg_addr == A_STATUS) ? reg_wdata[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~st_clr) | st_set;
  end

  always_ff @(posedge clk) begin
    if (rst)                            ovf_cnt <= '0;
    else if (drop_start && ovf_cnt != '1) ovf_cnt <= ovf_cnt + OVF_W'(1);
  end

  assign irq = (status[ST_HALF] && enable[0]) || (status[ST_AGE] && enable[1]);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_BASE:   reg_rdata = 32'(base);
      A_LEN:    reg_rdata = 32'(len);
      A_RDIDX:  reg_rdata = 32'(rd_idx);
      A_WRIDX:  reg_rdata = 32'(wr_idx);
      A_TMO:    reg_rdata = 32'(tmo);
      A_ENABLE: reg_rdata = 32'(enable);
      A_STATUS: reg_rdata = 32'(status);
      A_OCC:    reg_rdata = 32'(occ);
      A_OVF:    reg_rdata = 32'(ovf_cnt);
      default:  reg_rdata = '0;
    endcase
  end

  // R5: the read index stays inside the programmed length
  p_rd_range_r5: assert property (@(posedge clk) disable iff (rst) rd_idx < len);
  // R4: hardware alone never moves the read index
  p_rd_sw_only_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_idx) |-> $past(reg_wr));
  // R8: an interrupt always has a recorded cause behind it
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status[ST_HALF] || status[ST_AGE]));
  // R3: the overflow count only moves on a dropped record
  p_ovf_step_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(ovf_cnt) |-> $past(drop_start));
  // R2: memory writes stay inside the queue region
  p_addr_region_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr >= base && mem_addr < base + ADDR_W'(len) * ADDR_W'(REC_WORDS)));
endmodule

// File: tb/tb_rq_queue_ctl.sv
`timescale 1ns/1ps
module tb_rq_queue_ctl;
  localparam int RW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  rq_queue_ctl dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // push one record; exp_slot < 0 means the record must be dropped
  task automatic push(input int base, input int exp_slot, input logic [15:0] seed);
    for (int i = 0; i < RW; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = seed + 16'(i);
      #1;
      chk("R3 in_ready", 32'(in_ready), 32'd1);
      if (exp_slot < 0) begin
        chk("R3 drop no write", 32'(mem_we), 32'd0);
      end else begin
        chk("R2 mem_we", 32'(mem_we), 32'd1);
        chk("R2 mem_addr", 32'(mem_addr), 32'(base + exp_slot * RW + i));
        chk("R2 mem_wdata", 32'(mem_wdata), 32'(seed + 16'(i)));
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rreg(4'd2, v); chk("R1 rd", v, 0);
    rreg(4'd3, v); chk("R1 wr", v, 0);
    rreg(4'd1, v); chk("R1 len", v, 8);
    rreg(4'd4, v); chk("R1 tmo", v, 100);
    rreg(4'd5, v); chk("R1 enable", v, 0);
    rreg(4'd6, v); chk("R1 status", v, 0);
    rreg(4'd8, v); chk("R1 ovf", v, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_wrap_full();
    logic [31:0] v;
    wreg(4'd0, 32'h40);
    wreg(4'd1, 4);
    rreg(4'd3, v); chk("R10 wr cleared", v, 0);
    push(32'h40, 0, 16'h1000);
    push(32'h40, 1, 16'h2000);
    push(32'h40, 2, 16'h3000);
    rreg(4'd3, v); chk("R2 wr after 3", v, 3);
    rreg(4'd7, v); chk("R4 occ full", v, 3);
    push(32'h40, -1, 16'h4000);
    rreg(4'd3, v); chk("R3 wr held", v, 3);
    rreg(4'd8, v); chk("R3 ovf", v, 1);
    wreg(4'd2, 2);
    rreg(4'd2, v); chk("R4 rd written", v, 2);
    rreg(4'd7, v); chk("R4 occ", v, 1);
    push(32'h40, 3, 16'h5000);
    rreg(4'd3, v); chk("R2 wrap to 0", v, 0);
    rreg(4'd7, v); chk("R4 occ wrapped", v, 2);
    rreg(4'd2, v); chk("R4 rd unmoved by hw", v, 2);
  endtask

  task automatic t_rd_err();
    logic [31:0] v;
    wreg(4'd6, 7);
    wreg(4'd2, 4);
    rreg(4'd2, v); chk("R5 rd ignored", v, 2);
    rreg(4'd6, v); chk("R5 err bit", v & 4, 4);
    wreg(4'd1, 1);
    rreg(4'd1, v); chk("R10 short len ignored", v, 4);
  endtask

  task automatic t_half_irq();
    logic [31:0] v;
    wreg(4'd4, 32'hFFFF);
    wreg(4'd1, 8);
    wreg(4'd0, 0);
    wreg(4'd6, 7);
    for (int k = 0; k < 4; k++) push(0, k, 16'(k * 16));
    wait_cyc(2);
    rreg(4'd6, v); chk("R6 half not at 4/8", v & 1, 0);
    push(0, 4, 16'h0500);
    wait_cyc(2);
    rreg(4'd6, v); chk("R6 half at 5/8", v & 1, 1);
    chk("R8 irq disabled", 32'(irq), 0);
    wreg(4'd5, 2);
    wait_cyc(1);
    chk("R8 irq wrong enable", 32'(irq), 0);
    wreg(4'd5, 1);
    wait_cyc(1);
    chk("R8 irq half", 32'(irq), 1);
    wreg(4'd6, 1);
    wait_cyc(1);
    rreg(4'd6, v); chk("R9 resets while cause held", v & 1, 1);
    wreg(4'd2, 5);
    wreg(4'd6, 1);
    wait_cyc(2);
    rreg(4'd6, v); chk("R9 cleared", v & 1, 0);
    chk("R8 irq drops", 32'(irq), 0);
    wreg(4'd6, 0);
    rreg(4'd6, v); chk("R9 zero write no effect", v & 1, 0);
  endtask

  task automatic t_age();
    logic [31:0] v;
    wreg(4'd5, 0);
    wreg(4'd4, 10);
    wreg(4'd1, 8);
    wreg(4'd6, 7);
    wait_cyc(40);
    rreg(4'd6, v); chk("R7 no age while empty", v & 2, 0);
    push(0, 0, 16'hA000);
    push(0, 1, 16'hB000);
    wait_cyc(2);
    rreg(4'd6, v); chk("R7 young", v & 2, 0);
    wreg(4'd2, 1);
    wait_cyc(6);
    rreg(4'd6, v); chk("R7 restarted by rd write", v & 2, 0);
    wait_cyc(12);
    rreg(4'd6, v); chk("R7 aged", v & 2, 2);
    chk("R8 irq age masked", 32'(irq), 0);
    wreg(4'd5, 2);
    wait_cyc(1);
    chk("R8 irq age", 32'(irq), 1);
  endtask

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_wrap_full();
    t_rd_err();
    t_half_irq();
    t_age();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule